// File: doc/BRIEF.md
# Serial Flash Status Byte Protection Logic

This block holds the first status byte of a serial flash device and the software protection state of its sectors. The SPI front end decodes a write to this byte and passes the eight data bits in. Of those bits only the most significant one, the protection lock, is kept in a register. The middle four bits are never stored. They are decoded as a request to protect every sector at once or to unprotect every sector at once. The block also keeps one protection flag per sector. A separate command port lets the front end set or clear a single sector's flag.

The status byte that the block returns is built fresh every cycle. It holds the stored lock bit, the live state of the active-low write-protect pin, and a two-bit summary that tells whether none, some or all of the sectors are protected. When the lock is set and the write-protect pin is asserted, the whole byte is frozen. When the lock is set alone, only the sector flags are frozen, and a write can still clear the lock.

The write port follows valid/ready rules. `wr_ready` is held high, so the block never applies back-pressure. A write is accepted in any cycle where `wr_valid` is high. Its effect shows on the outputs after the next rising clock edge.

Top module: `status_prot_unit`

## Requirements
- R1: After reset the lock bit is 0 and every sector flag is 1, so with `wp_n` high the status byte reads 0x0C.
- R2: An accepted write stores only data bit 7 as the lock bit. Status bits 6, 5, 1 and 0 always read 0.
- R3: Status bit 4 reads 1 exactly while `wp_n` is low. It follows the pin in the same cycle, with no clock edge needed.
- R4: Status bits 3:2 read 00 when no sector flag is set, 01 when some are set and 11 when all are set. They never read 10.
- R5: An accepted write made while the lock is 0, with data bits 5:2 all 1 (for example 3Ch or 7Fh), sets every sector flag.
- R6: An accepted write made while the lock is 0, with data bits 5:2 all 0 (for example 00h), clears every sector flag.
- R7: Any other pattern in data bits 5:2 leaves the sector flags unchanged. For example, F0h sets the lock and 0Fh clears it, and neither touches a flag.
- R8: While the lock is 1 and `wp_n` is high, a write still updates the lock from data bit 7, but the block ignores the global protect and global unprotect decode.
- R9: While the lock is 1 and `wp_n` is low, every write is ignored: the lock and all sector flags keep their values.
- R10: A sector command (`sec_valid` high) with the lock at 0 writes `sec_set` into the flag chosen by `sec_idx`. While the lock is 1 the block ignores sector commands.
- R11: If a global protect or global unprotect lands in the same cycle as a sector command, the global action applies to every sector, including the one the sector command named.
- R12: `wr_ready` is always 1. A write takes effect at the clock edge where it is accepted. The lock in force before that edge decides whether the write is gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A status-byte write is offered |
| wr_ready | output | 1 | Block accepts the write; always 1 |
| wr_data | input | 8 | Data byte of the status write |
| wp_n | input | 1 | Write-protect pin, active low |
| sec_valid | input | 1 | Single-sector protection command |
| sec_idx | input | SECT_W | Index of the sector addressed by the command |
| sec_set | input | 1 | 1 protects the sector, 0 unprotects it |
| status_byte | output | 8 | Assembled first status byte |
| sector_prot | output | NSECT | One protection flag per sector |

## Verification
A status write that decodes as global protect or global unprotect can land in the same cycle as a single-sector command. The bench provokes this by raising `wr_valid` and `sec_valid` on the same negative edge. It does this both with a sector set against a global unprotect and with a sector clear against a global protect. It then checks that the flag vector is uniformly all-ones or all-zeros, with the addressed sector matching the others. The main sweep drives all 256 data values from every combination of lock state, pin level and starting flag pattern (none, some, all protected). It compares the status byte and the flags against a model computed in the bench.

// File: rtl/status_prot_pkg.sv
package status_prot_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned LOCK_BIT = 7;
  localparam int unsigned WP_BIT   = 4;

  typedef enum logic [1:0] {
    COVER_NONE = 2'b00,
    COVER_SOME = 2'b01,
    COVER_ALL  = 2'b11
  } cover_e;

  typedef struct packed {
    logic protect_all;
    logic clear_all;
  } global_req_t;
endpackage

// File: rtl/status_lock_ctl.sv
module status_lock_ctl
  import status_prot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wp_active,
  output logic              lock_q,
  output global_req_t       greq
);
  logic frozen;
  logic [3:0] cmd_field;

  assign frozen    = lock_q & wp_active;
  assign cmd_field = wr_data[5:2];

  always_comb begin
    greq = '0;
    if (wr_fire && !lock_q) begin
      greq.protect_all = (cmd_field == 4'hF);
      greq.clear_all   = (cmd_field == 4'h0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      lock_q <= 1'b0;
    else if (wr_fire && !frozen)
      lock_q <= wr_data[LOCK_BIT];
  end

  AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wp_active) |=> $stable(lock_q)); // R9

  AST_LOCK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wp_active) |=> (lock_q == $past(wr_data[LOCK_BIT]))); // R2
endmodule

// File: rtl/sector_flag_bank.sv
module sector_flag_bank
  import status_prot_pkg::*;
#(
  parameter int unsigned NSECT  = 16,
  parameter int unsigned SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  global_req_t       greq,
  input  logic              sec_valid,
  input  logic [SECT_W-1:0] sec_idx,
  input  logic              sec_set,
  output logic [NSECT-1:0]  flags
);
  genvar g;
  generate
    for (g = 0; g < NSECT; g++) begin : g_sect
      logic hit;
      assign hit = sec_valid && !lock_i && (sec_idx == SECT_W'(g));
      always_ff @(posedge clk) begin
        if (!rst_n)
          flags[g] <= 1'b1;
        else if (greq.protect_all)
          flags[g] <= 1'b1;
        else if (greq.clear_all)
          flags[g] <= 1'b0;
        else if (hit)
          flags[g] <= sec_set;
      end
    end
  endgenerate

  AST_GP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    greq.protect_all |=> (&flags)); // R5

  AST_GU_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    greq.clear_all |=> (flags == '0)); // R6

  AST_LOCKED_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> $stable(flags)); // R10
endmodule

// File: rtl/prot_cover_summary.sv
module prot_cover_summary
  import status_prot_pkg::*;
#(
  parameter int unsigned NSECT = 16
) (
  input  logic [NSECT-1:0] flags,
  output cover_e           cover_code
);
  logic all_set, any_set;
  assign all_set = &flags;
  assign any_set = |flags;

  always_comb begin
    if (all_set)      cover_code = COVER_ALL;
    else if (any_set) cover_code = COVER_SOME;
    else              cover_code = COVER_NONE;
  end

  always_comb begin
    AST_NO_CODE_10: assert (cover_code != cover_e'(2'b10)); // R4
  end
endmodule

// File: rtl/status_prot_unit.sv
module status_prot_unit
  import status_prot_pkg::*;
#(
  parameter int unsigned NSECT  = 16,
  parameter int unsigned SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  input  logic              wp_n,
  input  logic              sec_valid,
  input  logic [SECT_W-1:0] sec_idx,
  input  logic              sec_set,
  output logic [7:0]        status_byte,
  output logic [NSECT-1:0]  sector_prot
);
  logic        wr_fire;
  logic        wp_active;
  logic        lock_q;
  global_req_t greq;
  cover_e      cover_code;

  assign wr_ready  = 1'b1;
  assign wr_fire   = wr_valid & wr_ready;
  assign wp_active = ~wp_n;

  status_lock_ctl u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (wr_fire),
    .wr_data   (wr_data),
    .wp_active (wp_active),
    .lock_q    (lock_q),
    .greq      (greq)
  );

  sector_flag_bank #(.NSECT(NSECT), .SECT_W(SECT_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_i    (lock_q),
    .greq      (greq),
    .sec_valid (sec_valid),
    .sec_idx   (sec_idx),
    .sec_set   (sec_set),
    .flags     (sector_prot)
  );

  prot_cover_summary #(.NSECT(NSECT)) u_sum (
    .flags      (sector_prot),
    .cover_code (cover_code)
  );

  always_comb begin
    status_byte           = '0;
    status_byte[LOCK_BIT] = lock_q;
    status_byte[WP_BIT]   = wp_active;
    status_byte[3:2]      = cover_code;
  end

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[6:5] == 2'b00) && (status_byte[1:0] == 2'b00)); // R2

  AST_FROZEN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[LOCK_BIT] && !wp_n) |=> $stable(sector_prot)); // R9
endmodule

// File: tb/test_status_prot_unit.sv
module test_status_prot_unit;
  localparam int NS = 4;
  localparam int SW = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_valid = 0;
  logic wr_ready;
  logic [7:0] wr_data = 0;
  logic wp_n = 1;
  logic sec_valid = 0;
  logic [SW-1:0] sec_idx = 0;
  logic sec_set = 0;
  logic [7:0] status_byte;
  logic [NS-1:0] sector_prot;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  status_prot_unit #(.NSECT(NS), .SECT_W(SW)) i_status_prot_unit (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wp_n(wp_n), .sec_valid(sec_valid), .sec_idx(sec_idx),
    .sec_set(sec_set), .status_byte(status_byte), .sector_prot(sector_prot)
  );

  function automatic logic [7:0] model_status(logic lk, logic wpn, logic [NS-1:0] f);
    logic [1:0] c;
    c = (&f) ? 2'b11 : ((|f) ? 2'b01 : 2'b00);
    return {lk, 2'b00, ~wpn, c, 2'b00};
  endfunction

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_valid = 1; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic sec(int i, logic s);
    @(negedge clk); sec_valid = 1; sec_idx = SW'(i); sec_set = s;
    @(negedge clk); sec_valid = 0;
  endtask

  task automatic setup(logic lk, logic [NS-1:0] pat);
    wp_n = 1;
    wr(8'h0F);
    wr(8'h00);
    for (int i = 0; i < NS; i++) if (pat[i]) sec(i, 1'b1);
    if (lk) wr(8'hF0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NS-1:0] pats [3];
    pats[0] = '0; pats[1] = 4'b0101; pats[2] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk8("R1 status", status_byte, 8'h0C);
    chk8("R1 flags", {4'h0, sector_prot}, 8'h0F);
    // R12 ready always high
    chk8("R12 wr_ready", {7'h0, wr_ready}, 8'h01);
    // R3 live pin
    #1 wp_n = 0; #0.5;
    chk8("R3 wp low", status_byte, 8'h1C);
    wp_n = 1; #0.5;
    chk8("R3 wp high", status_byte, 8'h0C);

    // Sweep: R2 R4 R5 R6 R7 R8 R9
    for (int l = 0; l < 2; l++)
      for (int w = 0; w < 2; w++)
        for (int p = 0; p < 3; p++)
          for (int d = 0; d < 256; d++) begin
            logic [7:0] dv;
            logic nl;
            logic [NS-1:0] nf;
            dv = 8'(d);
            setup(l[0], pats[p]);
            wp_n = w[0];
            nl = l[0]; nf = pats[p];
            if (!(l[0] && !w[0])) begin
              nl = dv[7];
              if (!l[0]) begin
                if (dv[5:2] == 4'hF) nf = '1;
                else if (dv[5:2] == 4'h0) nf = '0;
              end
            end
            wr(dv);
            chk8("R2/R4/R8/R9 status", status_byte, model_status(nl, w[0], nf));
            chk8("R5/R6/R7/R9 flags", {4'h0, sector_prot}, {4'h0, nf});
          end

    // R10 sector command with lock 0 and lock 1
    setup(1'b0, 4'b0000);
    sec(2, 1'b1);
    chk8("R10 set unlocked", {4'h0, sector_prot}, 8'h04);
    chk8("R4 some", status_byte, 8'h04);
    wr(8'hF0);
    sec(1, 1'b1);
    chk8("R10 locked ignored", {4'h0, sector_prot}, 8'h04);
    wp_n = 1; wr(8'h0F);
    sec(2, 1'b0);
    chk8("R10 clear unlocked", {4'h0, sector_prot}, 8'h00);

    // R11 collision: global unprotect vs sector set
    setup(1'b0, 4'b0000);
    @(negedge clk);
    wr_valid = 1; wr_data = 8'h00; sec_valid = 1; sec_idx = 2'd3; sec_set = 1;
    @(negedge clk);
    wr_valid = 0; sec_valid = 0;
    chk8("R11 unprotect wins", {4'h0, sector_prot}, 8'h00);
    // R11 collision: global protect vs sector clear
    @(negedge clk);
    wr_valid = 1; wr_data = 8'h3C; sec_valid = 1; sec_idx = 2'd1; sec_set = 0;
    @(negedge clk);
    wr_valid = 0; sec_valid = 0;
    chk8("R11 protect wins", {4'h0, sector_prot}, 8'h0F);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule